// File: doc/BRIEF.md
# Single-Cycle Subset RISC Processor

A 32-bit processor core that fetches, decodes, executes and retires one instruction per clock cycle. It runs a small load/store instruction subset: five register-to-register operations (add, subtract, and, or, signed set-less-than), an or with a zero-extended immediate, word load, word store and a branch taken when two registers are equal. Everything between two clock edges is combinational: instruction fetch, register read, operand extension, ALU, data memory read and next-PC selection. Only the program counter, the register file and the data memory change state at the rising edge.

Decoding happens at two levels. A main decoder looks only at the opcode. It drives the datapath selects and a 2-bit ALU intent code. A small local ALU decoder turns that intent into a 3-bit ALU operation, and it reads the function field only when the intent is "register format". Both 256-word memories are filled through a valid/ready load stream. `ld_ready` is high only while reset is asserted, so the stream's back-pressure rule is simple: a word is accepted on a rising edge where `ld_valid` and `ld_ready` are both high, and a word offered while the core runs waits forever and is never written. Register-file writes and data-memory writes leave the core as plain observation pins.

Top module: `sc_cpu`

## Requirements
- R1: While `rst` is high (synchronous, active high), every rising edge sets `pc` to 0 and clears all registers to 0. `rf_we` and `dm_we` stay low during reset.
- R2: Every instruction other than a taken branch advances `pc` by 4. A taken branch loads `pc + 4 + (sign-extended imm[15:0] << 2)`. Instructions are fetched from word `pc[9:2]`.
- R3: Opcode 000000 is register format. R[rd] (instr[15:11]) receives R[rs] op R[rt], with rs = instr[25:21], rt = instr[20:16], and function field instr[5:0] set to add 100000, sub 100010, and 100100 or or 100101.
- R4: Function field 101010 writes 1 to R[rd] when R[rs] < R[rt] as signed 32-bit values, and 0 otherwise.
- R5: Opcode 001101 writes R[rs] OR {16'b0, imm} into R[rt].
- R6: Opcode 100011 writes into R[rt] the data word at index `A[9:2]`, where A = R[rs] + sign-extended imm. The two low address bits are ignored.
- R7: Opcode 101011 raises `dm_we` with `dm_addr` = R[rs] + sign-extended imm and `dm_wdata` = R[rt]. The word lands at index `dm_addr[9:2]`, and `rf_we` stays low.
- R8: Opcode 000100 compares R[rs] with R[rt] by subtraction and branches when they are equal. It raises neither `rf_we` nor `dm_we`.
- R9: Register 0 always reads as zero. A write aimed at it is ignored.
- R10: `ld_ready` equals `rst`. An accepted word goes to `ld_addr` of the instruction memory (`ld_target` = 0) or of the data memory (`ld_target` = 1). A word offered after reset is never written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| ld_valid | input | 1 | Load stream word valid |
| ld_ready | output | 1 | Load stream ready (high only in reset) |
| ld_target | input | 1 | 0 = instruction memory, 1 = data memory |
| ld_addr | input | 8 | Word index to load |
| ld_data | input | 32 | Word to load |
| pc | output | 32 | Address of the instruction executing this cycle |
| rf_we | output | 1 | Register write this cycle |
| rf_waddr | output | 5 | Destination register |
| rf_wdata | output | 32 | Value written to the destination |
| dm_we | output | 1 | Data memory write this cycle |
| dm_addr | output | 32 | Data memory byte address (ALU result) |
| dm_wdata | output | 32 | Data memory store value |

## Verification
On every cycle the assertions check the following: reset returns the PC to zero, the PC steps by four whenever no branch is decoded, stores never assert a register write, branches assert neither write strobe, register 0 reads as zero, and the set-less-than result is a single bit. The actual values are shown only by the bench's scenarios. These include the arithmetic results, zero versus sign extension, load data with a negative offset, the taken and not-taken branch targets, the dropped write to register 0, and a load word refused after reset. The bench runs a directed prefix and then a seeded random program, and compares each retired instruction against an instruction-level reference model.

// File: rtl/sc_pkg.sv
package sc_pkg;
  localparam int XLEN = 32;

  localparam logic [5:0] OPC_REG  = 6'b000000;
  localparam logic [5:0] OPC_ORI  = 6'b001101;
  localparam logic [5:0] OPC_LOAD = 6'b100011;
  localparam logic [5:0] OPC_STOR = 6'b101011;
  localparam logic [5:0] OPC_BEQ  = 6'b000100;

  localparam logic [5:0] FN_ADD = 6'b100000;
  localparam logic [5:0] FN_SUB = 6'b100010;
  localparam logic [5:0] FN_AND = 6'b100100;
  localparam logic [5:0] FN_OR  = 6'b100101;
  localparam logic [5:0] FN_SLT = 6'b101010;

  typedef enum logic [1:0] {
    INTENT_ADD   = 2'b00,
    INTENT_SUB   = 2'b01,
    INTENT_OR    = 2'b10,
    INTENT_FIELD = 2'b11
  } alu_intent_e;

  typedef enum logic [2:0] {
    ALU_AND = 3'b000,
    ALU_OR  = 3'b001,
    ALU_ADD = 3'b010,
    ALU_SUB = 3'b110,
    ALU_SLT = 3'b111
  } alu_op_e;

  typedef struct packed {
    logic        dst_is_rd;
    logic        b_from_imm;
    logic        sign_ext;
    logic        mem_write;
    logic        load_sel;
    logic        reg_write;
    logic        branch;
    alu_intent_e intent;
  } ctrl_t;
endpackage

// File: rtl/sc_main_dec.sv
module sc_main_dec
  import sc_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [5:0] opcode,
  output ctrl_t      ctrl
);
  always_comb begin
    ctrl = '{dst_is_rd: 1'b1, b_from_imm: 1'b1, sign_ext: 1'b1, mem_write: 1'b0,
             load_sel: 1'b0, reg_write: 1'b0, branch: 1'b0, intent: INTENT_ADD};
    case (opcode)
      OPC_REG: begin
        ctrl.b_from_imm = 1'b0;
        ctrl.reg_write  = 1'b1;
        ctrl.intent     = INTENT_FIELD;
      end
      OPC_ORI: begin
        ctrl.dst_is_rd = 1'b0;
        ctrl.sign_ext  = 1'b0;
        ctrl.reg_write = 1'b1;
        ctrl.intent    = INTENT_OR;
      end
      OPC_LOAD: begin
        ctrl.dst_is_rd = 1'b0;
        ctrl.load_sel  = 1'b1;
        ctrl.reg_write = 1'b1;
      end
      OPC_STOR: ctrl.mem_write = 1'b1;
      OPC_BEQ: begin
        ctrl.b_from_imm = 1'b0;
        ctrl.branch     = 1'b1;
        ctrl.intent     = INTENT_SUB;
      end
      default: ;
    endcase
  end

  AST_STORE_NO_REGWR: assert property (@(posedge clk) disable iff (rst)
    ctrl.mem_write |-> !ctrl.reg_write); // R7
endmodule

// File: rtl/sc_alu_dec.sv
module sc_alu_dec
  import sc_pkg::*;
(
  input  alu_intent_e intent,
  input  logic [5:0]  funct,
  output alu_op_e     op
);
  always_comb begin
    unique case (intent)
      INTENT_ADD: op = ALU_ADD;
      INTENT_SUB: op = ALU_SUB;
      INTENT_OR:  op = ALU_OR;
      default: begin
        case (funct)
          FN_ADD:  op = ALU_ADD;
          FN_SUB:  op = ALU_SUB;
          FN_OR:   op = ALU_OR;
          FN_SLT:  op = ALU_SLT;
          default: op = ALU_AND;
        endcase
      end
    endcase
  end
endmodule

// File: rtl/sc_alu.sv
module sc_alu
  import sc_pkg::*;
(
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  input  alu_op_e         op,
  output logic [XLEN-1:0] y,
  output logic            zero
);
  always_comb begin
    case (op)
      ALU_AND: y = a & b;
      ALU_OR:  y = a | b;
      ALU_ADD: y = a + b;
      ALU_SUB: y = a - b;
      ALU_SLT: y = {{(XLEN-1){1'b0}}, ($signed(a) < $signed(b))};
      default: y = '0;
    endcase
  end
  assign zero = (y == '0);
endmodule

// File: rtl/sc_regfile.sv
module sc_regfile #(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] ra1,
  input  logic [ADDR_W-1:0] ra2,
  output logic [DATA_W-1:0] rd1,
  output logic [DATA_W-1:0] rd2
);
  localparam int NREGS = 1 << ADDR_W;
  logic [DATA_W-1:0] regs [NREGS];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREGS; i++) regs[i] <= '0;
    end else if (we && waddr != '0) begin
      regs[waddr] <= wdata;
    end
  end

  assign rd1 = (ra1 == '0) ? '0 : regs[ra1];
  assign rd2 = (ra2 == '0) ? '0 : regs[ra2];

  AST_R0_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
    (ra2 == '0) |-> (rd2 == '0)); // R9
endmodule

// File: rtl/sc_cpu.sv
module sc_cpu
  import sc_pkg::*;
#(
  parameter int MEM_WORDS = 256
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         ld_valid,
  output logic                         ld_ready,
  input  logic                         ld_target,
  input  logic [$clog2(MEM_WORDS)-1:0] ld_addr,
  input  logic [31:0]                  ld_data,
  output logic [31:0]                  pc,
  output logic                         rf_we,
  output logic [4:0]                   rf_waddr,
  output logic [31:0]                  rf_wdata,
  output logic                         dm_we,
  output logic [31:0]                  dm_addr,
  output logic [31:0]                  dm_wdata
);
  localparam int AW = $clog2(MEM_WORDS);

  logic [31:0] imem [MEM_WORDS];
  logic [31:0] dmem [MEM_WORDS];
  logic        ld_fire;
  logic [31:0] instr, imm_ext, rs_val, rt_val, alu_b, alu_y, pc_next4, br_target;
  logic [4:0]  f_rs, f_rt, f_rd;
  logic        alu_zero;
  ctrl_t       ctrl;
  alu_op_e     alu_op;

  assign ld_ready = rst;
  assign ld_fire  = ld_valid & ld_ready;

  always_ff @(posedge clk) begin
    if (ld_fire && !ld_target) imem[ld_addr] <= ld_data;
  end

  always_ff @(posedge clk) begin
    if (ld_fire && ld_target) dmem[ld_addr] <= ld_data;
    else if (dm_we)           dmem[alu_y[AW+1:2]] <= rt_val;
  end

  assign instr = imem[pc[AW+1:2]];
  assign f_rs  = instr[25:21];
  assign f_rt  = instr[20:16];
  assign f_rd  = instr[15:11];

  sc_main_dec u_main_dec (.clk(clk), .rst(rst), .opcode(instr[31:26]), .ctrl(ctrl));
  sc_alu_dec  u_alu_dec  (.intent(ctrl.intent), .funct(instr[5:0]), .op(alu_op));

  assign imm_ext = ctrl.sign_ext ? {{16{instr[15]}}, instr[15:0]} : {16'b0, instr[15:0]};

  sc_regfile #(.ADDR_W(5), .DATA_W(XLEN)) u_regfile (
    .clk(clk), .rst(rst), .we(rf_we), .waddr(rf_waddr), .wdata(rf_wdata),
    .ra1(f_rs), .ra2(f_rt), .rd1(rs_val), .rd2(rt_val)
  );

  assign alu_b = ctrl.b_from_imm ? imm_ext : rt_val;
  sc_alu u_alu (.a(rs_val), .b(alu_b), .op(alu_op), .y(alu_y), .zero(alu_zero));

  assign dm_we    = ctrl.mem_write & ~rst;
  assign dm_addr  = alu_y;
  assign dm_wdata = rt_val;
  assign rf_we    = ctrl.reg_write & ~rst;
  assign rf_waddr = ctrl.dst_is_rd ? f_rd : f_rt;
  assign rf_wdata = ctrl.load_sel ? dmem[alu_y[AW+1:2]] : alu_y;

  assign pc_next4  = pc + 32'd4;
  assign br_target = pc_next4 + {imm_ext[29:0], 2'b00};

  always_ff @(posedge clk) begin
    if (rst) pc <= '0;
    else     pc <= (ctrl.branch && alu_zero) ? br_target : pc_next4;
  end

  AST_PC_RESET: assert property (@(posedge clk)
    rst |=> (pc == '0)); // R1
  AST_PC_SEQUENTIAL: assert property (@(posedge clk) disable iff (rst)
    !ctrl.branch |=> (pc == $past(pc) + 32'd4)); // R2
  AST_BEQ_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    ctrl.branch |-> (!rf_we && !dm_we)); // R8
  AST_SLT_IS_BOOL: assert property (@(posedge clk) disable iff (rst)
    (alu_op == ALU_SLT) |-> (alu_y[31:1] == '0)); // R4
endmodule

// File: tb/test_sc_cpu.sv
module test_sc_cpu;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ld_valid = 1'b0, ld_target = 1'b0;
  logic [7:0]  ld_addr = '0;
  logic [31:0] ld_data = '0;
  logic        ld_ready, rf_we, dm_we;
  logic [31:0] pc, rf_wdata, dm_addr, dm_wdata;
  logic [4:0]  rf_waddr;

  int n_checks = 0;
  int n_fail   = 0;

  logic [31:0] mimem [256];
  logic [31:0] mdmem [256];
  logic [31:0] mregs [32];
  logic [31:0] mpc;

  localparam logic [31:0] PROBE_PC = 32'd52;

  always #2 clk = ~clk;

  sc_cpu i_sc_cpu (
    .clk(clk), .rst(rst), .ld_valid(ld_valid), .ld_ready(ld_ready), .ld_target(ld_target),
    .ld_addr(ld_addr), .ld_data(ld_data), .pc(pc), .rf_we(rf_we), .rf_waddr(rf_waddr),
    .rf_wdata(rf_wdata), .dm_we(dm_we), .dm_addr(dm_addr), .dm_wdata(dm_wdata)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s at model pc=%0h: actual=%h expected=%h", req, what, mpc, act, exp);
    end
  endtask

  function automatic logic [31:0] enc_r(int rs, int rt, int rd, logic [5:0] fn);
    return {6'b000000, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
  endfunction

  function automatic logic [31:0] enc_i(logic [5:0] op, int rs, int rt, logic [15:0] imm);
    return {op, 5'(rs), 5'(rt), imm};
  endfunction

  function automatic logic [31:0] ref_alu(logic [5:0] fn, logic [31:0] a, logic [31:0] b);
    case (fn)
      6'b100000: return a + b;
      6'b100010: return a - b;
      6'b100100: return a & b;
      6'b100101: return a | b;
      default:   return ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
    endcase
  endfunction

  function automatic logic [31:0] gen_rand();
    logic [5:0] fns [5] = '{6'b100000, 6'b100010, 6'b100100, 6'b100101, 6'b101010};
    int k = $urandom % 10;
    int rs = $urandom % 8, rt = $urandom % 8, rd = $urandom % 8;
    if (k < 4)      return enc_r(rs, rt, rd, fns[$urandom % 5]);
    else if (k < 5) return enc_i(6'b001101, rs, rt, 16'($urandom));
    else if (k < 7) return enc_i(6'b100011, rs, rt, 16'($urandom));
    else if (k < 9) return enc_i(6'b101011, rs, rt, 16'($urandom));
    else            return enc_i(6'b000100, rs, rt, 16'(int'($urandom % 10) - 3));
  endfunction

  task automatic step_and_check();
    logic [31:0] ins = mimem[mpc[9:2]];
    logic [5:0]  op  = ins[31:26];
    int rs = ins[25:21], rt = ins[20:16], rd = ins[15:11];
    logic [31:0] a = mregs[rs], b = mregs[rt];
    logic [31:0] sx = {{16{ins[15]}}, ins[15:0]};
    logic        e_rfwe = 1'b0, e_dmwe = 1'b0;
    logic [4:0]  e_wa = '0;
    logic [31:0] e_wd = '0, e_da = '0, e_dd = '0, nxt = mpc + 32'd4;
    string tag = "R2";
    case (op)
      6'b000000: begin
        e_rfwe = 1'b1; e_wa = 5'(rd); e_wd = ref_alu(ins[5:0], a, b);
        tag = (ins[5:0] == 6'b101010) ? "R4" : "R3";
      end
      6'b001101: begin e_rfwe = 1'b1; e_wa = 5'(rt); e_wd = a | {16'b0, ins[15:0]}; tag = "R5"; end
      6'b100011: begin e_rfwe = 1'b1; e_wa = 5'(rt); e_wd = mdmem[(a + sx) >> 2 & 32'hFF]; tag = "R6"; end
      6'b101011: begin e_dmwe = 1'b1; e_da = a + sx; e_dd = b; tag = (rt == 0) ? "R9" : "R7"; end
      default: begin
        tag = "R8";
        if (a == b) nxt = mpc + 32'd4 + {sx[29:0], 2'b00};
      end
    endcase
    if (mpc == PROBE_PC) tag = "R10";
    if (op == 6'b000000 && rd == 0) tag = "R9";
    chk("R2", "pc", pc, mpc);
    chk(tag, "rf_we", 32'(rf_we), 32'(e_rfwe));
    chk(tag, "dm_we", 32'(dm_we), 32'(e_dmwe));
    if (e_rfwe) begin
      chk(tag, "rf_waddr", 32'(rf_waddr), 32'(e_wa));
      chk(tag, "rf_wdata", rf_wdata, e_wd);
      if (e_wa != 0) mregs[e_wa] = e_wd;
    end
    if (e_dmwe) begin
      chk(tag, "dm_addr", dm_addr, e_da);
      chk(tag, "dm_wdata", dm_wdata, e_dd);
      mdmem[e_da[9:2]] = e_dd;
    end
    mpc = nxt;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired: actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0421));
    mimem[0]  = enc_i(6'b001101, 0, 1, 16'hFFFF);
    mimem[1]  = enc_i(6'b001101, 0, 2, 16'h0100);
    mimem[2]  = enc_i(6'b100011, 2, 3, 16'hFFFC);
    mimem[3]  = enc_r(0, 1, 4, 6'b100010);
    mimem[4]  = enc_r(4, 1, 5, 6'b101010);
    mimem[5]  = enc_r(1, 4, 6, 6'b101010);
    mimem[6]  = enc_r(1, 4, 7, 6'b100100);
    mimem[7]  = enc_r(7, 3, 7, 6'b100101);
    mimem[8]  = enc_r(1, 1, 0, 6'b100000);
    mimem[9]  = enc_i(6'b101011, 2, 0, 16'h0008);
    mimem[10] = enc_i(6'b000100, 0, 0, 16'h0001);
    mimem[11] = enc_r(1, 1, 1, 6'b100000);
    mimem[12] = enc_i(6'b000100, 1, 0, 16'h0005);
    mimem[13] = enc_i(6'b100011, 0, 8, 16'h0014);
    for (int i = 14; i < 256; i++) mimem[i] = gen_rand();
    for (int i = 0; i < 256; i++) mdmem[i] = $urandom;
    for (int i = 0; i < 32; i++) mregs[i] = '0;
    mpc = '0;

    for (int i = 0; i < 512; i++) begin
      @(negedge clk);
      ld_valid  = 1'b1;
      ld_target = (i >= 256);
      ld_addr   = 8'(i);
      ld_data   = (i >= 256) ? mdmem[i - 256] : mimem[i];
    end
    @(negedge clk);
    ld_valid = 1'b0;
    @(negedge clk);
    chk("R1", "pc in reset", pc, 32'd0);
    chk("R1", "rf_we in reset", 32'(rf_we), 32'd0);
    chk("R1", "dm_we in reset", 32'(dm_we), 32'd0);
    chk("R10", "ld_ready in reset", 32'(ld_ready), 32'd1);

    rst       = 1'b0;
    ld_valid  = 1'b1;
    ld_target = 1'b1;
    ld_addr   = 8'd5;
    ld_data   = 32'hDEAD_BEEF;
    #1;
    chk("R10", "ld_ready after reset", 32'(ld_ready), 32'd0);
    step_and_check();
    @(negedge clk);
    ld_valid = 1'b0;
    #1;
    for (int c = 1; c < 800; c++) begin
      step_and_check();
      @(negedge clk);
      #1;
    end
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule